// File: doc/BRIEF.md
# Audio Interface Clock Generator

This block derives the bit clock and the frame (left/right) clock of a serial audio link from one fast master clock running at 256 times the sample rate. In master mode it divides the master clock internally. A selectable pre-divider of 1, 2 or 4 ahead of the frame divider gives the base sample-rate family, the half-rate family or the quarter-rate family from the same source. In slave mode it synchronises an externally supplied bit clock and frame clock into the master-clock domain and drives them onto the same outputs.

All divided clocks are produced as registered levels and enables inside the master-clock domain; no new clock nets are created. A small controller with three states governs the outputs. `S_HALT` clears every counter and holds both clock outputs low. `S_MASTER` runs the dividers. `S_SLAVE` forwards the synchronised external clocks. The named transitions are:
- **reset**: into `S_HALT`.
- **go_master** and **go_slave**: leave `S_HALT` after exactly one cycle, chosen by the mode select.
- **reconfig**: back to `S_HALT` when, in `S_MASTER`, the mode select or the rate code changes.
- **leave_slave**: back to `S_HALT` when, in `S_SLAVE`, the mode select returns to master.

A one-cycle sample strobe marks each falling edge of the frame clock output.

Top module: `audio_clkgen`

## Requirements
- R1: While reset is asserted, `bclk_o`, `lrclk_o` and `sample_stb` are 0. After reset the controller spends exactly one cycle in `S_HALT` before it enters `S_MASTER` or `S_SLAVE`.
- R2: In master mode the bit clock output has a period of 4×P master cycles, where P is the pre-divide ratio. It is high for 2×P cycles and low for 2×P cycles.
- R3: In master mode the frame clock output has a period of 256×P master cycles. It is low for the first 128×P cycles (left half) and high for 128×P cycles (right half), and each frame holds exactly 64 bit-clock rising edges.
- R4: The rate code `rate_sel` selects P: 2'b00 gives P=1, 2'b01 gives P=2, 2'b10 gives P=4, and 2'b11 also gives P=4.
- R5: In master mode every transition of `lrclk_o` happens in the same cycle as a falling edge of `bclk_o`.
- R6: `sample_stb` is high for exactly one cycle: the first cycle in which `lrclk_o` is low after having been high. This holds in both modes.
- R7: In slave mode, `bclk_o` and `lrclk_o` equal `ext_bclk` and `ext_lrclk` as they were three master-clock cycles earlier (two synchroniser stages plus one output register).
- R8: A change of `rate_sel` or `slave_mode` while in master mode causes the following: both clock outputs are low two cycles later; the controller passes through `S_HALT` for one cycle; the dividers restart from frame start, so `lrclk_o` then stays low for 128×P further cycles.
- R9: In slave mode `rate_sel` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256 × base sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = forward external clocks, 0 = divide internally |
| rate_sel | input | 2 | Pre-divide code for the sample-rate family |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External frame clock (slave mode) |
| bclk_o | output | 1 | Selected bit clock |
| lrclk_o | output | 1 | Selected frame clock |
| sample_stb | output | 1 | One-cycle pulse after each frame-clock falling edge |

## Verification
In master mode, a frame-clock edge and a bit-clock falling edge fall in the same cycle by design. Each rate code is swept over whole frames, and every frame-clock transition is checked against a simultaneous bit-clock fall, with periods, duty and edges per frame compared to values computed from P. A rate change is forced while the frame clock is high, so the forced low output of the halt state and the sample strobe coincide. The bench judges that the strobe still fires once and that the restart lands exactly 128×P cycles before the next rising frame edge.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    typedef enum logic [1:0] {
        S_HALT   = 2'd0,
        S_MASTER = 2'd1,
        S_SLAVE  = 2'd2
    } clk_state_e;

    // Pre-divide ratio per rate code; the top code reuses the deepest ratio.
    function automatic int unsigned prediv_ratio(input logic [1:0] code);
        unique case (code)
            2'b00:   prediv_ratio = 1;
            2'b01:   prediv_ratio = 2;
            default: prediv_ratio = 4;
        endcase
    endfunction

endpackage

// File: rtl/clk_rate_prediv.sv
module clk_rate_prediv
    import audio_clk_pkg::*;
#(
    parameter int MAX_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int CW = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_c;

    assign last_c = CW'(prediv_ratio(code) - 1);
    assign tick   = run && (cnt == last_c);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R4: the pre-divide counter never passes the ratio chosen by the code
    a_r4_prediv_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last_c));

endmodule

// File: rtl/clk_frame_div.sv
module clk_frame_div #(
    parameter int FRAME_DIV = 256,
    parameter int BCLK_DIV  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bclk_lvl,
    output logic lr_lvl
);
    localparam int FW = $clog2(FRAME_DIV);
    localparam int BW = $clog2(BCLK_DIV);

    logic [FW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Bit clock and frame clock taken from one counter keep a fixed phase.
    assign bclk_lvl = cnt[BW-1];
    assign lr_lvl   = cnt[FW-1];

    // R3: without a tick the frame position holds
    a_r3_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/clk_sync_chain.sv
module clk_sync_chain #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clk_pkg::*;
#(
    parameter int FRAME_DIV   = 256,
    parameter int BCLK_DIV    = 4,
    parameter int MAX_PREDIV  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slave_mode,
    input  logic [1:0] rate_sel,
    input  logic       ext_bclk,
    input  logic       ext_lrclk,
    output logic       bclk_o,
    output logic       lrclk_o,
    output logic       sample_stb
);
    clk_state_e state, state_nx;
    logic [1:0] rate_run;
    logic       tick, div_bclk, div_lr;
    logic [1:0] ext_sync;
    logic       bclk_q, lrclk_q, lr_prev;
    logic       halt;

    assign halt = (state == S_HALT);

    clk_rate_prediv #(.MAX_DIV(MAX_PREDIV)) i_prediv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (halt),
        .run   (state == S_MASTER),
        .code  (rate_run),
        .tick  (tick)
    );

    clk_frame_div #(.FRAME_DIV(FRAME_DIV), .BCLK_DIV(BCLK_DIV)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (halt),
        .tick     (tick),
        .bclk_lvl (div_bclk),
        .lr_lvl   (div_lr)
    );

    clk_sync_chain #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ext_lrclk, ext_bclk}),
        .q     (ext_sync)
    );

    // Next-state logic: go_master, go_slave, reconfig, leave_slave
    always_comb begin
        state_nx = state;
        unique case (state)
            S_HALT:   state_nx = slave_mode ? S_SLAVE : S_MASTER;
            S_MASTER: if (slave_mode || (rate_sel != rate_run)) state_nx = S_HALT;
            S_SLAVE:  if (!slave_mode) state_nx = S_HALT;
            default:  state_nx = S_HALT;
        endcase
    end

    // State register; the rate code is captured only while halted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_HALT;
            rate_run <= 2'b00;
        end else begin
            state <= state_nx;
            if (halt) rate_run <= rate_sel;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q  <= 1'b0;
            lrclk_q <= 1'b0;
            lr_prev <= 1'b0;
        end else begin
            lr_prev <= lrclk_q;
            unique case (state)
                S_MASTER: begin
                    bclk_q  <= div_bclk;
                    lrclk_q <= div_lr;
                end
                S_SLAVE: begin
                    bclk_q  <= ext_sync[0];
                    lrclk_q <= ext_sync[1];
                end
                default: begin
                    bclk_q  <= 1'b0;
                    lrclk_q <= 1'b0;
                end
            endcase
        end
    end

    assign bclk_o     = bclk_q;
    assign lrclk_o    = lrclk_q;
    assign sample_stb = lr_prev & ~lrclk_q;

    // R1 / R8: a halt cycle drives both clock outputs low
    a_r1_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT) |=> (!bclk_q && !lrclk_q));

    // R8: the halt state lasts a single cycle
    a_r8_halt_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HALT) |=> (state != S_HALT));

    // R5: divided frame-clock edges land on a bit-clock fall
    a_r5_lr_on_bclk_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == S_MASTER) && ($rose(lrclk_q) || $fell(lrclk_q))) |-> $fell(bclk_q));

    // R6: the strobe is a single-cycle pulse
    a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R6: every frame-clock fall raises the strobe
    a_r6_stb_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lrclk_q) |-> sample_stb);

endmodule

// File: tb/test_audio_clkgen.sv
module test_audio_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_mode = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       ext_bclk = 1'b0;
    logic       ext_lrclk = 1'b0;
    logic       bclk_o, lrclk_o, sample_stb;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    audio_clkgen i_audio_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .rate_sel   (rate_sel),
        .ext_bclk   (ext_bclk),
        .ext_lrclk  (ext_lrclk),
        .bclk_o     (bclk_o),
        .lrclk_o    (lrclk_o),
        .sample_stb (sample_stb)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Sweep whole frames in master mode for one rate code (R2, R3, R4, R5, R6)
    task automatic run_master(input logic [1:0] code, input int p);
        logic pb, pl;
        int   wait_cyc, lastrise, cyc_total;
        slave_mode = 1'b0;
        rate_sel   = code;
        repeat (20) @(negedge clk);
        pb = bclk_o; pl = lrclk_o;
        wait_cyc = 0;
        while (!sample_stb && wait_cyc < 3000) begin
            @(negedge clk);
            wait_cyc++;
        end
        chk(sample_stb, "R6", "frame start found", int'(sample_stb), 1);
        pb = bclk_o; pl = lrclk_o;
        lastrise = -1; cyc_total = 0;
        for (int f = 0; f < 2; f++) begin
            int cyc, hi, rises, perr, aerr, serr;
            cyc = 0; hi = 0; rises = 0; perr = 0; aerr = 0; serr = 0;
            do begin
                @(negedge clk);
                cyc++; cyc_total++;
                if (lrclk_o) hi++;
                if (bclk_o && !pb) begin
                    rises++;
                    if (lastrise >= 0 && (cyc_total - lastrise) != 4*p) perr++;
                    lastrise = cyc_total;
                end
                if ((lrclk_o != pl) && !(pb && !bclk_o)) aerr++;
                if (sample_stb != (pl && !lrclk_o)) serr++;
                pb = bclk_o; pl = lrclk_o;
            end while (!sample_stb && cyc < 5000);
            chk(cyc == 256*p, "R3", "frame period", cyc, 256*p);
            chk(hi == 128*p, "R3", "right-half length", hi, 128*p);
            chk(rises == 64, "R3", "bit clocks per frame", rises, 64);
            chk(perr == 0, "R2", "bit clock period errors", perr, 0);
            chk(aerr == 0, "R5", "frame edges off a bit-clock fall", aerr, 0);
            chk(serr == 0, "R6", "strobe mismatches", serr, 0);
        end
        // R4: the code maps to P; the bit clock period shows it directly
        chk(lastrise > 0, "R4", "rate code produced bit clocks", lastrise > 0, 1);
    endtask

    // Slave forwarding with a latency of three cycles (R7, R6, R9)
    task automatic run_slave();
        localparam int N = 600;
        logic hb [N];
        logic hl [N];
        int   berr, lerr, serr, r9err;
        berr = 0; lerr = 0; serr = 0; r9err = 0;
        ext_bclk = 1'b0; ext_lrclk = 1'b0;
        slave_mode = 1'b1;
        repeat (8) @(negedge clk);
        for (int n = 0; n < N; n++) begin
            @(negedge clk);
            if (n >= 3) begin
                if (bclk_o != hb[n-3]) berr++;
                if (lrclk_o != hl[n-3]) lerr++;
                if (n >= 300 && (bclk_o != hb[n-3] || lrclk_o != hl[n-3])) r9err++;
            end
            if (n >= 4 && sample_stb != (hl[n-4] && !hl[n-3])) serr++;
            if (n == 300) rate_sel = ~rate_sel;
            ext_bclk  = ((n / 3) % 2) == 1;
            ext_lrclk = ((n / 96) % 2) == 1;
            hb[n] = ext_bclk;
            hl[n] = ext_lrclk;
        end
        chk(berr == 0, "R7", "slave bit clock mismatches", berr, 0);
        chk(lerr == 0, "R7", "slave frame clock mismatches", lerr, 0);
        chk(serr == 0, "R6", "slave strobe mismatches", serr, 0);
        chk(r9err == 0, "R9", "outputs moved after rate change in slave", r9err, 0);
    endtask

    // Rate change while the frame clock is high (R8)
    task automatic run_restart(input logic [1:0] new_code, input int new_p);
        int lows, guard;
        guard = 0;
        while (!lrclk_o && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        rate_sel = new_code;
        @(negedge clk);
        @(negedge clk);
        chk(!bclk_o && !lrclk_o, "R8", "outputs low after reconfig",
            {30'd0, lrclk_o, bclk_o}, 0);
        lows = 0;
        do begin
            @(negedge clk);
            if (!lrclk_o) lows++;
        end while (!lrclk_o && lows < 5000);
        chk(lows == 128*new_p, "R8", "left half after restart", lows, 128*new_p);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(!bclk_o && !lrclk_o && !sample_stb, "R1", "outputs during reset",
            {29'd0, sample_stb, lrclk_o, bclk_o}, 0);
        rst_n = 1'b1;
        run_master(2'b00, 1);
        run_master(2'b01, 2);
        run_restart(2'b10, 4);
        run_master(2'b10, 4);
        run_master(2'b11, 4);
        run_slave();
        run_master(2'b00, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule